// File: doc/BRIEF.md
# Data Trace Synchronization Message Encoder

This block turns captured data bus accesses into variable-length trace messages for a debug trace unit. Each accepted access carries an address, a data value, a size code and a direction. The block emits one packed message word and its valid bit count to a downstream message queue. The message is either a synchronization message that holds the full address, or a compressed message that holds only the address bits that differ from a rolling reference address. In both forms the leading zeros of the address field and of the data field are dropped.

Many unrelated events can require that the next message be a synchronization message. These are reset, trace being switched on, leaving a low-power or debug mode, an external event-in pulse, a blocked access to secure memory, a message lost in a queue collision, and a periodic limit. All of them fold into one pending flag. A message counter provides the periodic limit.

Top module: `dtsync_encoder`

## Requirements
- R1: After reset `msgValid` is 0 and `msgLen` is 0. The first message after reset is a synchronization message.
- R2: The message type sits in bits [5:0]. A synchronization write is 13, a synchronization read is 14, a compressed write is 5 and a compressed read is 6. `srcId` sits in bits [9:6] and the size code in bits [12:10].
- R3: A synchronization message holds the full access address in its address field, starting at bit 13. The field width is the position of the highest set bit plus one, and at least 1. The message loads the reference address.
- R4: A compressed message holds the address XOR the reference address in the same stripped field. The reference address then becomes the access address.
- R5: The data field follows straight after the address field. It holds the data masked by size code 0=8, 1=16, 2=32 or 3..7=64 bits, stripped to its highest set bit and at least 1 bit wide. `msgLen` is 13 plus both field widths (15 to 109), and all bits above `msgLen` are 0.
- R6: While `traceEn` is 0, accesses produce no message. The first access once `traceEn` is 1 again, including an access in the same cycle as the enable, is a synchronization message.
- R7: A `lowPowerExit` pulse makes the next access a synchronization message.
- R8: An `eventIn` pulse while `traceEn` and `eventSel` are 1 makes the next access a synchronization message. With `eventSel` at 0 it has no effect.
- R9: An access with `accSecure` set produces no message. The next access is a synchronization message.
- R10: A `collisionLost` pulse makes the next access a synchronization message.
- R11: After a synchronization message, 255 compressed messages follow. The next message after them is a synchronization message.
- R12: A forcing input in the same cycle as an access applies to that access. A synchronization message clears every pending request, so the next access is compressed.
- R13: `msgValid` is a one-cycle pulse on the clock edge after the accepted access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| traceEn | input | 1 | Data trace enable |
| eventIn | input | 1 | External event pulse |
| eventSel | input | 1 | Lets eventIn force synchronization |
| lowPowerExit | input | 1 | Pulse on leaving a low-power or debug mode |
| collisionLost | input | 1 | Pulse when a data message was lost at queue entry |
| accValid | input | 1 | An access is present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSecure | input | 1 | The access targets secure memory |
| accSize | input | 3 | Size code of the access |
| srcId | input | 4 | Source identifier placed in the message |
| accAddr | input | 32 | Access address |
| accData | input | 64 | Access data |
| msgValid | output | 1 | A message is presented this cycle |
| msgBits | output | 109 | Packed message, LSB first |
| msgLen | output | 7 | Number of valid message bits |

## Verification
A forcing request and the periodic limit can reach the same access as an ordinary compressed message. The bench raises `eventIn` in the same cycle as an access and checks two things: that access must come out as a synchronization message, and the access right after it must be compressed against the newly loaded reference. The periodic limit is reached by a run of 255 compressed accesses after a synchronization message. The bench checks that exactly the next message is a synchronization message.

// File: rtl/dtsync_pkg.sv
package dtsync_pkg;

  localparam int HDR_W    = 13;
  localparam int SRC_LSB  = 6;
  localparam int DSZ_LSB  = 10;

  localparam logic [5:0] TC_SYNC_WR = 6'd13;
  localparam logic [5:0] TC_SYNC_RD = 6'd14;
  localparam logic [5:0] TC_CMP_WR  = 6'd5;
  localparam logic [5:0] TC_CMP_RD  = 6'd6;

  typedef struct packed {
    logic emit;
    logic sync;
    logic isWrite;
  } ctrlStrobe_t;

  // width of a value counted up to its highest set bit, never below one
  function automatic logic [6:0] sigBits(input logic [63:0] v);
    logic [6:0] n;
    n = 7'd1;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) n = 7'(i + 1);
    end
    return n;
  endfunction

endpackage

// File: rtl/dtsync_ctrl.sv
module dtsync_ctrl
  import dtsync_pkg::*;
#(
  parameter int SYNC_PERIOD = 255,
  localparam int CNT_W = $clog2(SYNC_PERIOD + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        traceEn,
  input  logic        eventIn,
  input  logic        eventSel,
  input  logic        lowPowerExit,
  input  logic        collisionLost,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic        accSecure,
  output ctrlStrobe_t strobe
);

  logic             enPrev;
  logic             pendingSync;
  logic [CNT_W-1:0] cmpCount;
  logic             takeAcc;
  logic             asyncReq;
  logic             periodDue;
  logic             forceNow;

  assign takeAcc   = accValid & traceEn;
  assign asyncReq  = (traceEn & ~enPrev) | lowPowerExit | collisionLost
                   | (eventIn & eventSel & traceEn);
  assign periodDue = (cmpCount == CNT_W'(SYNC_PERIOD));
  assign forceNow  = pendingSync | asyncReq | periodDue;

  always_comb begin
    strobe.emit    = takeAcc & ~accSecure;
    strobe.sync    = takeAcc & ~accSecure & forceNow;
    strobe.isWrite = accWrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev      <= 1'b0;
      pendingSync <= 1'b1;
      cmpCount    <= '0;
    end else begin
      enPrev <= traceEn;
      if (takeAcc && accSecure) begin
        pendingSync <= 1'b1;
      end else if (strobe.emit) begin
        pendingSync <= 1'b0;
      end else if (asyncReq) begin
        pendingSync <= 1'b1;
      end
      if (strobe.emit) begin
        cmpCount <= strobe.sync ? '0 : cmpCount + 1'b1;
      end
    end
  end

  // a blocked secure access leaves a synchronization request behind
  assert_secure_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    (traceEn && accValid && accSecure) |=> pendingSync);

  // compressed run never passes the periodic limit
  assert_period_limit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !strobe.sync) |=> (cmpCount != '0));

endmodule

// File: rtl/dtsync_dpath.sv
module dtsync_dpath
  import dtsync_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int MSG_W = HDR_W + ADDR_W + DATA_W,
  localparam int LEN_W = $clog2(MSG_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic [2:0]        accSize,
  input  logic [3:0]        srcId,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgBits,
  output logic [LEN_W-1:0]  msgLen
);

  logic [ADDR_W-1:0] refAddr;
  logic [ADDR_W-1:0] aField;
  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] dMasked;
  logic [LEN_W-1:0]  aBits;
  logic [LEN_W-1:0]  dBits;
  logic [5:0]        tcode;
  logic [MSG_W-1:0]  msgNext;
  logic [LEN_W-1:0]  lenNext;

  always_comb begin
    if (accSize >= 3'd3) sizeMask = '1;
    else                 sizeMask = (DATA_W'(1) << (6'd8 << accSize)) - DATA_W'(1);
  end

  always_comb begin
    unique case ({strobe.sync, strobe.isWrite})
      2'b11:   tcode = TC_SYNC_WR;
      2'b10:   tcode = TC_SYNC_RD;
      2'b01:   tcode = TC_CMP_WR;
      default: tcode = TC_CMP_RD;
    endcase
  end

  assign aField  = strobe.sync ? accAddr : (accAddr ^ refAddr);
  assign dMasked = accData & sizeMask;
  assign aBits   = LEN_W'(sigBits(64'(aField)));
  assign dBits   = LEN_W'(sigBits(64'(dMasked)));
  assign lenNext = LEN_W'(HDR_W) + aBits + dBits;

  always_comb begin
    msgNext = MSG_W'(tcode)
            | (MSG_W'(srcId)   << SRC_LSB)
            | (MSG_W'(accSize) << DSZ_LSB)
            | (MSG_W'(aField)  << HDR_W)
            | (MSG_W'(dMasked) << (LEN_W'(HDR_W) + aBits));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid <= 1'b0;
      msgBits  <= '0;
      msgLen   <= '0;
      refAddr  <= '0;
    end else begin
      msgValid <= strobe.emit;
      if (strobe.emit) begin
        msgBits <= msgNext;
        msgLen  <= lenNext;
        refAddr <= accAddr;
      end
    end
  end

  // every emitted message, sync or compressed, moves the reference
  assert_ref_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |=> (refAddr == $past(accAddr)));

  assert_len_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgLen >= LEN_W'(15) && msgLen <= LEN_W'(MSG_W)));

  assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.emit |=> !msgValid);

endmodule

// File: rtl/dtsync_encoder.sv
module dtsync_encoder
  import dtsync_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 64,
  parameter int SYNC_PERIOD = 255,
  localparam int MSG_W = HDR_W + ADDR_W + DATA_W,
  localparam int LEN_W = $clog2(MSG_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              traceEn,
  input  logic              eventIn,
  input  logic              eventSel,
  input  logic              lowPowerExit,
  input  logic              collisionLost,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accSecure,
  input  logic [2:0]        accSize,
  input  logic [3:0]        srcId,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accData,
  output logic              msgValid,
  output logic [MSG_W-1:0]  msgBits,
  output logic [LEN_W-1:0]  msgLen
);

  ctrlStrobe_t strobe;

  dtsync_ctrl #(.SYNC_PERIOD(SYNC_PERIOD)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .traceEn      (traceEn),
    .eventIn      (eventIn),
    .eventSel     (eventSel),
    .lowPowerExit (lowPowerExit),
    .collisionLost(collisionLost),
    .accValid     (accValid),
    .accWrite     (accWrite),
    .accSecure    (accSecure),
    .strobe       (strobe)
  );

  dtsync_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .accAddr (accAddr),
    .accData (accData),
    .accSize (accSize),
    .srcId   (srcId),
    .msgValid(msgValid),
    .msgBits (msgBits),
    .msgLen  (msgLen)
  );

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!traceEn && accValid) |=> !msgValid);

  assert_latency_R13: assert property (@(posedge clk) disable iff (!rstN)
    (traceEn && accValid && !accSecure) |=> msgValid);

endmodule

// File: tb/dtsync_encoder_bench.sv
module dtsync_encoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] SRC = 4'hA;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [63:0] data;
    logic [2:0]  dsz;
    logic        expSync;
    logic [5:0]  expTc;
    logic [6:0]  expLen;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b1, 32'h0000_1000, 64'h0000_0000_0000_00AB,          3'd0, 1'b1, 6'd13, 7'd34},
    '{1'b0, 32'h0000_1004, 64'h0000_0000_0000_1234,          3'd1, 1'b0, 6'd6,  7'd29},
    '{1'b1, 32'h0000_1004, 64'h0000_0000_0000_0000,          3'd2, 1'b0, 6'd5,  7'd15},
    '{1'b0, 32'h8000_0000, 64'hFFFF_FFFF_FFFF_FFFF,          3'd3, 1'b0, 6'd6,  7'd109},
    '{1'b1, 32'h8000_0000, 64'h0000_0000_0000_01FF,          3'd0, 1'b0, 6'd5,  7'd22}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic traceEn = 1'b1, eventIn = 1'b0, eventSel = 1'b0, lowPowerExit = 1'b0;
  logic collisionLost = 1'b0, accValid = 1'b0, accWrite = 1'b0, accSecure = 1'b0;
  logic [2:0]   accSize = '0;
  logic [3:0]   srcId = SRC;
  logic [31:0]  accAddr = '0;
  logic [63:0]  accData = '0;
  logic         msgValid;
  logic [108:0] msgBits;
  logic [6:0]   msgLen;

  int nChecks = 0;
  int nBad = 0;
  logic [31:0] refModel = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dtsync_encoder u_dtsync_encoder (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .eventIn(eventIn), .eventSel(eventSel),
    .lowPowerExit(lowPowerExit), .collisionLost(collisionLost), .accValid(accValid),
    .accWrite(accWrite), .accSecure(accSecure), .accSize(accSize), .srcId(srcId),
    .accAddr(accAddr), .accData(accData), .msgValid(msgValid), .msgBits(msgBits),
    .msgLen(msgLen)
  );

  function automatic int widthOf(input logic [63:0] v);
    int n = 1;
    for (int i = 0; i < 64; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare the presented message with one built from the requirements
  task automatic expectMsg(input bit sync, input bit wr, input logic [31:0] addr,
                           input logic [63:0] data, input logic [2:0] dsz, input string tag);
    logic [5:0]   tc;
    logic [31:0]  af;
    logic [63:0]  dm;
    logic [108:0] bits;
    int           aw, dw;
    tc = sync ? (wr ? 6'd13 : 6'd14) : (wr ? 6'd5 : 6'd6);
    af = sync ? addr : (addr ^ refModel);
    dm = (dsz >= 3) ? data : (data & ((64'd1 << (8 << dsz)) - 64'd1));
    aw = widthOf(64'(af));
    dw = widthOf(dm);
    bits = 109'(tc) | (109'(SRC) << 6) | (109'(dsz) << 10) | (109'(af) << 13)
         | (109'(dm) << (13 + aw));
    chk(msgValid === 1'b1, {tag, " valid"}, 128'(msgValid), 128'(1));
    chk(msgBits === bits, {tag, " bits"}, 128'(msgBits), 128'(bits));
    chk(msgLen === 7'(13 + aw + dw), {tag, " len"}, 128'(msgLen), 128'(13 + aw + dw));
    refModel = addr;
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [63:0] data,
                        input logic [2:0] dsz, input bit sec, input bit ev);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accAddr = addr; accData = data;
    accSize = dsz; accSecure = sec; eventIn = ev;
    @(negedge clk);
    accValid = 1'b0; accSecure = 1'b0; eventIn = 1'b0;
  endtask

  task automatic pulse(input bit ev, input bit lp, input bit col);
    @(negedge clk);
    eventIn = ev; lowPowerExit = lp; collisionLost = col;
    @(negedge clk);
    eventIn = 1'b0; lowPowerExit = 1'b0; collisionLost = 1'b0;
  endtask

  task automatic finish();
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) @(posedge clk);
    nChecks++;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(msgValid === 1'b0, "R1 reset valid", 128'(msgValid), 0);
    chk(msgLen === 7'd0, "R1 reset len", 128'(msgLen), 0);
    rstN = 1'b1;

    // table walk: sync first (R1, R3), then compressed forms (R2, R4, R5)
    foreach (VECS[i]) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].dsz, 1'b0, 1'b0);
      chk(msgBits[5:0] === VECS[i].expTc, "R2 tcode", 128'(msgBits[5:0]), 128'(VECS[i].expTc));
      chk(msgLen === VECS[i].expLen, "R5 table len", 128'(msgLen), 128'(VECS[i].expLen));
      expectMsg(VECS[i].expSync, VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].dsz,
                VECS[i].expSync ? "R3 table" : "R4 table");
    end

    // R13: the pulse lasts one cycle
    @(negedge clk);
    chk(msgValid === 1'b0, "R13 pulse end", 128'(msgValid), 0);

    // R6: disabled accesses are dropped, enable with an access syncs it
    traceEn = 1'b0;
    access(1'b1, 32'h0000_2000, 64'h5, 3'd0, 1'b0, 1'b0);
    chk(msgValid === 1'b0, "R6 disabled", 128'(msgValid), 0);
    @(negedge clk); traceEn = 1'b1;
    accValid = 1'b1; accWrite = 1'b0; accAddr = 32'h0000_2004; accData = 64'h7; accSize = 3'd0;
    @(negedge clk); accValid = 1'b0;
    expectMsg(1'b1, 1'b0, 32'h0000_2004, 64'h7, 3'd0, "R6 enable");
    access(1'b0, 32'h0000_2008, 64'h7, 3'd0, 1'b0, 1'b0);
    expectMsg(1'b0, 1'b0, 32'h0000_2008, 64'h7, 3'd0, "R6 after");

    // R8: event-in without its select has no effect, with it forces sync
    eventSel = 1'b0;
    pulse(1'b1, 1'b0, 1'b0);
    access(1'b1, 32'h0000_200C, 64'h1, 3'd1, 1'b0, 1'b0);
    expectMsg(1'b0, 1'b1, 32'h0000_200C, 64'h1, 3'd1, "R8 unselected");
    eventSel = 1'b1;
    pulse(1'b1, 1'b0, 1'b0);
    access(1'b1, 32'h0000_2010, 64'h1, 3'd1, 1'b0, 1'b0);
    expectMsg(1'b1, 1'b1, 32'h0000_2010, 64'h1, 3'd1, "R8 selected");

    // R12: event in the same cycle as the access, then compressed again
    access(1'b0, 32'h0000_3000, 64'hFF00, 3'd1, 1'b0, 1'b1);
    expectMsg(1'b1, 1'b0, 32'h0000_3000, 64'hFF00, 3'd1, "R12 same cycle");
    access(1'b0, 32'h0000_3001, 64'hFF00, 3'd1, 1'b0, 1'b0);
    expectMsg(1'b0, 1'b0, 32'h0000_3001, 64'hFF00, 3'd1, "R12 next compressed");

    // R9: secure access is silent, next access syncs
    access(1'b1, 32'h0000_4000, 64'h3, 3'd0, 1'b1, 1'b0);
    chk(msgValid === 1'b0, "R9 silent", 128'(msgValid), 0);
    access(1'b1, 32'h0000_3002, 64'h3, 3'd0, 1'b0, 1'b0);
    expectMsg(1'b1, 1'b1, 32'h0000_3002, 64'h3, 3'd0, "R9 next sync");

    // R10: collision loss
    pulse(1'b0, 1'b0, 1'b1);
    access(1'b0, 32'h0000_3003, 64'h3, 3'd0, 1'b0, 1'b0);
    expectMsg(1'b1, 1'b0, 32'h0000_3003, 64'h3, 3'd0, "R10 collision");

    // R7 then R11: low-power exit sync, 255 compressed, then periodic sync
    pulse(1'b0, 1'b1, 1'b0);
    access(1'b1, 32'h0001_0000, 64'h9, 3'd0, 1'b0, 1'b0);
    expectMsg(1'b1, 1'b1, 32'h0001_0000, 64'h9, 3'd0, "R7 low power");
    for (int k = 1; k <= 255; k++) begin
      access(1'b1, 32'h0001_0000 + 32'(k * 4), 64'(k), 3'd2, 1'b0, 1'b0);
      expectMsg(1'b0, 1'b1, 32'h0001_0000 + 32'(k * 4), 64'(k), 3'd2, "R11 run");
    end
    access(1'b0, 32'h0001_1000, 64'h9, 3'd0, 1'b0, 1'b0);
    expectMsg(1'b1, 1'b0, 32'h0001_1000, 64'h9, 3'd0, "R11 periodic");

    // R1: reset in mid run, first message is sync again
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk(msgValid === 1'b0, "R1 mid reset", 128'(msgValid), 0);
    rstN = 1'b1; refModel = '0;
    access(1'b1, 32'h0001_1004, 64'h9, 3'd0, 1'b0, 1'b0);
    expectMsg(1'b1, 1'b1, 32'h0001_1004, 64'h9, 3'd0, "R1 after reset");

    finish();
  end

endmodule